// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits beside a free-running timer counter. It holds a compare value written by the CPU and checks it for equality against the count on every timer tick. An equal count raises a sticky match flag and, when enabled, an interrupt request. The same event drives a waveform pin, which a two-bit action field sets, clears or toggles.

The counter, prescaler and waveform mode decoder stay outside the block. They supply the count, a tick enable, top and bottom strobes and a PWM-mode level. In PWM modes the compare value is double buffered, so a new value takes effect only at a chosen end of the count sequence and the pulse widths stay consistent. In the other modes a write takes effect at once.

The CPU can apply the pin action without a real match through a force strobe, which works only outside PWM modes. A write to the counter suppresses the match on the next timer tick.

Top module: `tmr_cmp_chan`

## Requirements
- R1: A synchronous reset clears the active compare value, the buffer, the flag and the pin to 0.
- R2: A tick cycle with count equal to the active compare value, not blocked by R10, makes the flag read 1 from the next clock cycle.
- R3: A one on `flag_clr` or `irq_ack` makes the flag read 0 on the next cycle. A match in the same cycle wins, and the flag stays 1.
- R4: `irq` is high exactly when the flag is 1 and `irq_en` is 1.
- R5: With `pwm_mode`=0, a `cmp_wr` loads `cmp_wdata` into the active compare value, visible on `cmp_active` the next cycle.
- R6: With `pwm_mode`=1, a `cmp_wr` loads only the buffer. The active value copies the buffer on a tick cycle whose selected strobe is high: `at_top` when `upd_at_top`=1, `at_bottom` when it is 0. At all other times the active value holds.
- R7: On a match the pin follows `pin_mode`: 00 keeps it, 01 toggles it, 10 drives 0, 11 drives 1.
- R8: With `pwm_mode`=0, a `force_stb` applies the R7 action to the pin on the next cycle and leaves the flag unchanged.
- R9: With `pwm_mode`=1, `force_stb` has no effect on the pin or the flag.
- R10: A `cnt_wr` suppresses the match on the first tick cycle strictly after the write. This holds however many tickless cycles pass in between. A tick in the write cycle itself still compares normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| count | input | CNT_W | Current counter value |
| at_top | input | 1 | Counter is at top |
| at_bottom | input | 1 | Counter is at bottom |
| pwm_mode | input | 1 | 1 when a PWM mode is active |
| upd_at_top | input | 1 | Buffer copy edge: 1 = top, 0 = bottom |
| cmp_wr | input | 1 | CPU write to the compare value |
| cmp_wdata | input | CNT_W | Compare write data |
| cnt_wr | input | 1 | CPU write to the counter took place |
| flag_clr | input | 1 | Software writes one to clear the flag |
| irq_ack | input | 1 | Interrupt serviced |
| irq_en | input | 1 | Interrupt enable |
| force_stb | input | 1 | Force compare strobe |
| pin_mode | input | 2 | Pin action on match |
| cmp_active | output | CNT_W | Active compare value |
| flag | output | 1 | Match flag |
| irq | output | 1 | Interrupt request |
| wave_out | output | 1 | Waveform pin |

## Verification
The assertions assume that `pwm_mode`, `upd_at_top` and `pin_mode` are levels, while the write, clear, acknowledge and force inputs are one-cycle pulses. They also assume that the count changes only around ticks. The stimulus changes levels only between pulses. It keeps the count fixed across tickless stretches, and it raises `force_stb` only on tickless cycles, so a forced pin change never overlaps a real match.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'b00,
        PIN_TOGGLE = 2'b01,
        PIN_LOW    = 2'b10,
        PIN_HIGH   = 2'b11
    } pin_act_e;

    typedef struct packed {
        logic hit;
        logic equal;
    } match_info_t;

    function automatic logic pin_next(pin_act_e act, logic cur);
        logic res;
        unique case (act)
            PIN_KEEP:   res = cur;
            PIN_TOGGLE: res = ~cur;
            PIN_LOW:    res = 1'b0;
            PIN_HIGH:   res = 1'b1;
            default:    res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/tcc_cmp_store.sv
module tcc_cmp_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic         pwm_mode,
    input  logic         upd_at_top,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] active
);
    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;
    logic         edge_sel;
    logic         do_copy;

    assign edge_sel = upd_at_top ? at_top : at_bottom;
    assign do_copy  = pwm_mode & tick & edge_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr_en) buf_q <= wr_data;
            if (wr_en && !pwm_mode) act_q <= wr_data;
            else if (do_copy)       act_q <= buf_q;
        end
    end

    assign active = act_q;
endmodule

// File: rtl/tcc_match_gate.sv
module tcc_match_gate
    import tmr_cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] count,
    input  logic [W-1:0] ref_val,
    output match_info_t  info
);
    logic [W-1:0] bit_eq;
    logic         block_q;

    for (genvar i = 0; i < W; i++) begin : g_eq
        assign bit_eq[i] = ~(count[i] ^ ref_val[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)         block_q <= 1'b0;
        else if (cnt_wr) block_q <= 1'b1;
        else if (tick)   block_q <= 1'b0;
    end

    assign info.equal = &bit_eq;
    assign info.hit   = tick & info.equal & ~block_q;
endmodule

// File: rtl/tcc_flag_unit.sv
module tcc_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tcc_pin_unit.sv
module tcc_pin_unit
    import tmr_cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       force_stb,
    input  logic       pwm_mode,
    input  logic [1:0] mode,
    output logic       pin
);
    logic pin_q;
    logic fire;

    assign fire = hit | (force_stb & ~pwm_mode);

    always_ff @(posedge clk) begin
        if (rst)       pin_q <= 1'b0;
        else if (fire) pin_q <= pin_next(pin_act_e'(mode), pin_q);
    end

    assign pin = pin_q;
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_cmp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic             at_top,
    input  logic             at_bottom,
    input  logic             pwm_mode,
    input  logic             upd_at_top,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cnt_wr,
    input  logic             flag_clr,
    input  logic             irq_ack,
    input  logic             irq_en,
    input  logic             force_stb,
    input  logic [1:0]       pin_mode,
    output logic [CNT_W-1:0] cmp_active,
    output logic             flag,
    output logic             irq,
    output logic             wave_out
);
    match_info_t minfo;

    tcc_cmp_store #(.W(CNT_W)) u_store (
        .clk, .rst, .tick, .at_top, .at_bottom, .pwm_mode, .upd_at_top,
        .wr_en(cmp_wr), .wr_data(cmp_wdata), .active(cmp_active)
    );

    tcc_match_gate #(.W(CNT_W)) u_match (
        .clk, .rst, .tick, .cnt_wr, .count,
        .ref_val(cmp_active), .info(minfo)
    );

    tcc_flag_unit u_flag (
        .clk, .rst, .set_i(minfo.hit), .clr_i(flag_clr | irq_ack), .flag_o(flag)
    );

    tcc_pin_unit u_pin (
        .clk, .rst, .hit(minfo.hit), .force_stb, .pwm_mode,
        .mode(pin_mode), .pin(wave_out)
    );

    assign irq = flag & irq_en;
endmodule

// File: rtl/tmr_cmp_chan_chk.sv
module tmr_cmp_chan_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic             pwm_mode,
    input logic             cmp_wr,
    input logic [CNT_W-1:0] cmp_wdata,
    input logic             cnt_wr,
    input logic             flag_clr,
    input logic             irq_ack,
    input logic             irq_en,
    input logic             force_stb,
    input logic [1:0]       pin_mode,
    input logic [CNT_W-1:0] cmp_active,
    input logic             flag,
    input logic             irq,
    input logic             wave_out
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!flag && !wave_out && cmp_active == '0)); // R1
    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick && count == cmp_active)); // R2
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((flag_clr || irq_ack) && !(tick && count == cmp_active)) |=> !flag); // R3
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en); // R4
    AST_IRQ_DROPS_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> !irq); // R4
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!pwm_mode && cmp_wr) |=> cmp_active == $past(cmp_wdata)); // R5
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && !tick) |=> $stable(cmp_active)); // R6
    AST_KEEP_MODE: assert property (@(posedge clk) disable iff (rst)
        (pin_mode == 2'b00) |=> $stable(wave_out)); // R7
    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (force_stb && !tick) |=> !$rose(flag)); // R8
    AST_FORCE_PWM_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && force_stb && !tick) |=> $stable(wave_out)); // R9
    AST_BLOCK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr ##1 tick) |=> !$rose(flag)); // R10
endmodule

bind tmr_cmp_chan tmr_cmp_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk, .rst, .tick, .count, .pwm_mode, .cmp_wr, .cmp_wdata, .cnt_wr,
    .flag_clr, .irq_ack, .irq_en, .force_stb, .pin_mode,
    .cmp_active, .flag, .irq, .wave_out
);

// File: tb/tmr_cmp_chan_tb_top.sv
module tmr_cmp_chan_tb_top;
    localparam int W = 8;

    typedef struct {
        logic         rst, tick, at_top, at_bottom, pwm, sel;
        logic         cmp_wr, cnt_wr, clr, ack, en, frc;
        logic [W-1:0] count, wdata;
        logic [1:0]   mode;
    } stim_t;

    typedef struct {
        logic         flag, irq, wave;
        logic [W-1:0] active;
        string        tag;
    } exp_t;

    logic clk = 0;
    always #5 clk = ~clk;

    logic         rst, tick, at_top, at_bottom, pwm_mode, upd_at_top;
    logic         cmp_wr, cnt_wr, flag_clr, irq_ack, irq_en, force_stb;
    logic [W-1:0] count, cmp_wdata, cmp_active;
    logic [1:0]   pin_mode;
    logic         flag, irq, wave_out;

    tmr_cmp_chan #(.CNT_W(W)) dut_i (
        .clk, .rst, .tick, .count, .at_top, .at_bottom, .pwm_mode, .upd_at_top,
        .cmp_wr, .cmp_wdata, .cnt_wr, .flag_clr, .irq_ack, .irq_en, .force_stb,
        .pin_mode, .cmp_active, .flag, .irq, .wave_out
    );

    exp_t  q[$];
    stim_t s;
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    logic         m_flag, m_wave, m_block;
    logic [W-1:0] m_active, m_buf;

    task automatic step(input string tag);
        logic hit, act;
        exp_t e;
        @(negedge clk);
        rst = s.rst; tick = s.tick; at_top = s.at_top; at_bottom = s.at_bottom;
        pwm_mode = s.pwm; upd_at_top = s.sel; cmp_wr = s.cmp_wr; cnt_wr = s.cnt_wr;
        flag_clr = s.clr; irq_ack = s.ack; irq_en = s.en; force_stb = s.frc;
        count = s.count; cmp_wdata = s.wdata; pin_mode = s.mode;
        if (s.rst) begin
            m_flag = 0; m_wave = 0; m_block = 0; m_active = 0; m_buf = 0;
        end else begin
            hit = s.tick && (s.count == m_active) && !m_block;
            act = hit || (s.frc && !s.pwm);
            if (hit) m_flag = 1;
            else if (s.clr || s.ack) m_flag = 0;
            if (act) begin
                case (s.mode)
                    2'b01: m_wave = ~m_wave;
                    2'b10: m_wave = 0;
                    2'b11: m_wave = 1;
                    default: m_wave = m_wave;
                endcase
            end
            if (!s.pwm && s.cmp_wr) m_active = s.wdata;
            else if (s.pwm && s.tick && (s.sel ? s.at_top : s.at_bottom)) m_active = m_buf;
            if (s.cmp_wr) m_buf = s.wdata;
            if (s.cnt_wr) m_block = 1;
            else if (s.tick) m_block = 0;
        end
        e.flag = m_flag; e.irq = m_flag & s.en; e.wave = m_wave;
        e.active = m_active; e.tag = tag;
        q.push_back(e);
        s.tick = 0; s.at_top = 0; s.at_bottom = 0; s.cmp_wr = 0; s.cnt_wr = 0;
        s.clr = 0; s.ack = 0; s.frc = 0; s.rst = 0;
    endtask

    always begin
        exp_t e;
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (flag !== e.flag || irq !== e.irq || wave_out !== e.wave ||
                cmp_active !== e.active) begin
                failures++;
                $display("FAIL %s: got flag=%b irq=%b wave=%b active=%h exp flag=%b irq=%b wave=%b active=%h",
                         e.tag, flag, irq, wave_out, cmp_active,
                         e.flag, e.irq, e.wave, e.active);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung exp finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        s = '{rst:1, tick:0, at_top:0, at_bottom:0, pwm:0, sel:0, cmp_wr:0,
              cnt_wr:0, clr:0, ack:0, en:0, frc:0, count:'0, wdata:'0, mode:2'b00};
        s.rst = 1; step("R1 reset");
        s.rst = 1; step("R1 reset");
        step("R1 idle after reset");
        // R5 direct load outside PWM
        s.cmp_wr = 1; s.wdata = 8'h40; step("R5 direct write");
        // R2 R7 R4 match with toggle and interrupt enabled
        s.mode = 2'b01; s.en = 1;
        s.tick = 1; s.count = 8'h3F; step("R2 no match");
        s.tick = 1; s.count = 8'h40; step("R2 R7 match toggles, R4 irq");
        s.en = 0; step("R4 irq masked");
        s.ack = 1; step("R3 ack clears");
        s.mode = 2'b10; s.tick = 1; step("R7 clear action");
        s.clr = 1; step("R3 write-one clears");
        s.mode = 2'b11; s.tick = 1; step("R7 set action");
        s.mode = 2'b00; s.clr = 1; step("R3 clear");
        s.tick = 1; step("R7 keep action");
        s.tick = 1; s.ack = 1; s.en = 1; step("R3 match beats ack");
        s.clr = 1; step("R3 clear again");
        // R8 force outside PWM
        s.mode = 2'b01; s.frc = 1; step("R8 force toggles, no flag");
        s.mode = 2'b10; s.frc = 1; step("R8 force clear");
        // R9 force ignored in PWM
        s.pwm = 1; s.mode = 2'b01; s.frc = 1; step("R9 force ignored");
        // R6 buffered update, bottom selected
        s.count = 8'h10; s.sel = 0;
        s.cmp_wr = 1; s.wdata = 8'h80; step("R6 write to buffer only");
        s.tick = 1; s.at_top = 1; step("R6 top ignored when bottom selected");
        s.at_bottom = 1; step("R6 strobe without tick");
        s.tick = 1; s.at_bottom = 1; step("R6 copy at bottom");
        s.sel = 1; s.cmp_wr = 1; s.wdata = 8'h22; step("R6 second buffer write");
        s.tick = 1; s.at_bottom = 1; step("R6 bottom ignored when top selected");
        s.tick = 1; s.at_top = 1; step("R6 copy at top");
        // R10 counter write blocking with timer stopped
        s.pwm = 0; s.count = 8'h22; s.mode = 2'b01; s.en = 0;
        s.clr = 1; step("R3 clear before block test");
        s.cnt_wr = 1; step("R10 counter write");
        step("R10 stopped");
        step("R10 stopped");
        s.tick = 1; step("R10 match blocked");
        s.tick = 1; step("R10 match after window");
        s.clr = 1; step("R10 clear");
        s.tick = 1; s.cnt_wr = 1; step("R10 write cycle compares normally");
        s.tick = 1; step("R10 following tick blocked");
        step("R10 settle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule